// File: doc/BRIEF.md
# Compact DCI Payload Sizer and Random-Access Field Packer

This block serves the downlink control path of a base-station physical layer. From the size of the initial downlink bandwidth part, counted in resource blocks, it works out how many bits a compact downlink control payload occupies. It supports two formats: a downlink assignment and an uplink grant. The uplink grant carries fewer fixed bits, so it is padded with zeros until its length equals the downlink assignment length. The block reports the resulting length and the number of padding bits on every clock.

The block also builds the payload for a downlink assignment addressed by a random-access identifier. When a start pulse arrives together with the random-access identifier type, the block clears a 64-bit payload register and captures the field values. It captures the current frequency-field width at the same time. It then writes one field per clock and raises a one-cycle done strobe when the last field is in place. The frequency-field width follows the bandwidth part: it is the ceiling of the base-two logarithm of the triangular number N(N+1)/2.

Top module: `dci_payload_unit`

## Requirements
- R1: The frequency-field width `w` is the smallest integer with 2^w >= N(N+1)/2, where N is the effective resource-block count. Examples: N=1 gives w=0, N=2 gives w=2, N=24 gives w=9, N=275 gives w=16.
- R2: `size_bits` equals 28 + w. It is registered and reflects the inputs sampled at the previous clock edge.
- R3: With `fmt_ul`=1 (uplink grant), the raw length is 20 + w. `pad_bits` reads 8, and `size_bits` still equals 28 + w. With `fmt_ul`=0 (downlink assignment), `pad_bits` reads 0.
- R4: An `n_rb` of 0 is treated as 1, and any value above 275 is treated as 275.
- R5: A start that is accepted at clock edge k raises `done` high after edge k+4, for exactly one cycle.
- R6: Fields are written MSB first into consecutive payload bits starting at bit 0. The order is: frequency (w bits), time assignment (4 bits, at bit w), MCS (5 bits, at bit w+4), TB scaling (2 bits, at bit w+9).
- R7: A start is accepted only when `rnti_kind` equals 1 (random access). The other codes are 0 cell, 2 paging and 3 system information. A start carrying any of these leaves `payload` unchanged and produces no `done`.
- R8: A start that arrives while packing is in progress is ignored. It neither alters the result in flight nor causes a second `done`.
- R9: The width w used for packing is the one in force at the accepted start edge. Later changes of `n_rb` affect `size_bits` only.
- R10: While `rst` is high, `size_bits`, `pad_bits`, `payload` and `done` are all zero.
- R11: Frequency-value bits above bit w-1 are discarded. After `done`, every payload bit at position w+11 or higher is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| n_rb | input | 9 | Bandwidth-part size in resource blocks |
| fmt_ul | input | 1 | 0 downlink assignment, 1 uplink grant |
| rnti_kind | input | 2 | Identifier type: 0 cell, 1 random access, 2 paging, 3 system info |
| start | input | 1 | Start pulse for packing |
| freq_val | input | 16 | Frequency assignment value |
| tdra_val | input | 4 | Time assignment value |
| mcs_val | input | 5 | Modulation and coding scheme |
| tbs_val | input | 2 | Transport block scaling |
| size_bits | output | 7 | Payload length in bits |
| pad_bits | output | 7 | Zero padding appended to the selected format |
| payload | output | 64 | Packed payload register |
| done | output | 1 | One-cycle strobe when packing has finished |

## Verification
Two functions can act in the same cycle. The size path tracks `n_rb` on every clock, while the packer works from the width it captured at start. The bench changes `n_rb` one cycle after an accepted start, then checks that `size_bits` moves to the new length while the finished payload still uses the old field positions. It also issues a second start in the middle of packing and confirms that the first result arrives on schedule and that no second strobe follows. A behavioural model, updated on every edge, predicts all four outputs, and the bench compares them against it each cycle.

// File: rtl/dci_pkg.sv
package dci_pkg;
    localparam int PAY_W    = 64;
    localparam int NRB_W    = 9;
    localparam int NRB_MAX  = 275;
    localparam int VAL_W    = 16;
    localparam int WID_W    = 5;
    localparam int SIZE_W   = 7;
    localparam int DL_FIXED = 28;
    localparam int UL_FIXED = 20;
    localparam int TDRA_W   = 4;
    localparam int MCS_W    = 5;
    localparam int TBS_W    = 2;
    localparam int TAIL_W   = TDRA_W + MCS_W + TBS_W;

    typedef enum logic [1:0] {
        RNTI_CELL    = 2'd0,
        RNTI_RACH    = 2'd1,
        RNTI_PAGE    = 2'd2,
        RNTI_SYSINFO = 2'd3
    } rnti_kind_t;

    typedef enum logic [2:0] {
        PK_IDLE, PK_FREQ, PK_TIME, PK_MCS, PK_TBS
    } pack_state_t;

    typedef struct packed {
        logic [VAL_W-1:0]  freq;
        logic [TDRA_W-1:0] tdra;
        logic [MCS_W-1:0]  mcs;
        logic [TBS_W-1:0]  tbs;
    } ra_fields_t;

    // Lay the low `len` bits of v into a zero vector, MSB at bit `pos`.
    function automatic logic [PAY_W-1:0] place_msb_first(
        input logic [VAL_W-1:0] v, input int len, input int pos);
        logic [PAY_W-1:0] r;
        r = '0;
        for (int i = 0; i < VAL_W; i++) begin
            if (i < len && (pos + i) < PAY_W)
                r[pos + i] = v[len - 1 - i];
        end
        return r;
    endfunction
endpackage

// File: rtl/dci_freq_width.sv
module dci_freq_width
    import dci_pkg::*;
#(
    parameter int NRB_W_P   = NRB_W,
    parameter int NRB_MAX_P = NRB_MAX,
    parameter int WID_W_P   = WID_W
) (
    input  logic [NRB_W_P-1:0] n_rb,
    output logic [WID_W_P-1:0] fw
);
    localparam int TRI_W = 2 * NRB_W_P;
    localparam logic [TRI_W-1:0] ONE_V = TRI_W'(1);

    logic [NRB_W_P-1:0] n_eff;
    logic [TRI_W-1:0]   prod_v;
    logic [TRI_W-1:0]   tri_v;

    // Clamp to the legal range, then form the triangular number.
    always_comb begin
        if (n_rb == '0)
            n_eff = NRB_W_P'(1);
        else if (n_rb > NRB_W_P'(NRB_MAX_P))
            n_eff = NRB_W_P'(NRB_MAX_P);
        else
            n_eff = n_rb;
        prod_v = TRI_W'(n_eff) * (TRI_W'(n_eff) + ONE_V);
        tri_v  = prod_v >> 1;
    end

    // Ceiling log2: the last power of two still below the value.
    always_comb begin
        fw = '0;
        for (int i = 0; i < TRI_W; i++) begin
            if (tri_v > (ONE_V << i))
                fw = WID_W_P'(i + 1);
        end
    end
endmodule

// File: rtl/dci_size_calc.sv
module dci_size_calc
    import dci_pkg::*;
#(
    parameter int WID_W_P    = WID_W,
    parameter int SIZE_W_P   = SIZE_W,
    parameter int DL_FIXED_P = DL_FIXED,
    parameter int UL_FIXED_P = UL_FIXED
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WID_W_P-1:0]  fw,
    input  logic                fmt_ul,
    output logic [SIZE_W_P-1:0] size_q,
    output logic [SIZE_W_P-1:0] pad_q
);
    localparam int MAX_SIZE = DL_FIXED_P + VAL_W;

    logic [SIZE_W_P-1:0] dl_len, ul_raw, pad_n;

    always_comb begin
        dl_len = SIZE_W_P'(DL_FIXED_P) + SIZE_W_P'(fw);
        ul_raw = SIZE_W_P'(UL_FIXED_P) + SIZE_W_P'(fw);
        pad_n  = fmt_ul ? (dl_len - ul_raw) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= '0;
            pad_q  <= '0;
        end else begin
            size_q <= fmt_ul ? (ul_raw + pad_n) : dl_len;
            pad_q  <= pad_n;
        end
    end

    a_r2_size_range: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (size_q >= SIZE_W_P'(DL_FIXED_P) && size_q <= SIZE_W_P'(MAX_SIZE)));
    a_r3_ul_pad: assert property (@(posedge clk) disable iff (rst)
        (!rst && fmt_ul) |=> (pad_q == SIZE_W_P'(DL_FIXED_P - UL_FIXED_P)));
    a_r3_dl_no_pad: assert property (@(posedge clk) disable iff (rst)
        (!rst && !fmt_ul) |=> (pad_q == '0));
endmodule

// File: rtl/dci_ra_packer.sv
module dci_ra_packer
    import dci_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [WID_W-1:0] fw,
    input  ra_fields_t       fields,
    output logic [PAY_W-1:0] payload,
    output logic             done
);
    pack_state_t      state;
    logic [WID_W-1:0] fw_c;
    ra_fields_t       f_c;
    logic [VAL_W-1:0] sel_v;
    int               sel_len, sel_pos;

    // Field selection per step; offsets follow the captured width.
    always_comb begin
        sel_v = '0; sel_len = 0; sel_pos = 0;
        case (state)
            PK_FREQ: begin sel_v = f_c.freq;             sel_len = int'(fw_c); sel_pos = 0; end
            PK_TIME: begin sel_v = VAL_W'(f_c.tdra);     sel_len = TDRA_W;     sel_pos = int'(fw_c); end
            PK_MCS:  begin sel_v = VAL_W'(f_c.mcs);      sel_len = MCS_W;      sel_pos = int'(fw_c) + TDRA_W; end
            PK_TBS:  begin sel_v = VAL_W'(f_c.tbs);      sel_len = TBS_W;      sel_pos = int'(fw_c) + TDRA_W + MCS_W; end
            default: begin sel_v = '0; sel_len = 0; sel_pos = 0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PK_IDLE;
            payload <= '0;
            done    <= 1'b0;
            fw_c    <= '0;
            f_c     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                PK_IDLE: if (go) begin
                    payload <= '0;
                    fw_c    <= fw;
                    f_c     <= fields;
                    state   <= PK_FREQ;
                end
                PK_FREQ: begin payload <= payload | place_msb_first(sel_v, sel_len, sel_pos); state <= PK_TIME; end
                PK_TIME: begin payload <= payload | place_msb_first(sel_v, sel_len, sel_pos); state <= PK_MCS;  end
                PK_MCS:  begin payload <= payload | place_msb_first(sel_v, sel_len, sel_pos); state <= PK_TBS;  end
                PK_TBS:  begin
                    payload <= payload | place_msb_first(sel_v, sel_len, sel_pos);
                    done    <= 1'b1;
                    state   <= PK_IDLE;
                end
                default: state <= PK_IDLE;
            endcase
        end
    end

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (state == PK_TBS) |=> done);
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == PK_IDLE && !go) |=> $stable(payload));
    a_r11_upper_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> ((payload >> (int'(fw_c) + TAIL_W)) == '0));
endmodule

// File: rtl/dci_payload_unit.sv
module dci_payload_unit
    import dci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NRB_W-1:0]  n_rb,
    input  logic              fmt_ul,
    input  logic [1:0]        rnti_kind,
    input  logic              start,
    input  logic [VAL_W-1:0]  freq_val,
    input  logic [TDRA_W-1:0] tdra_val,
    input  logic [MCS_W-1:0]  mcs_val,
    input  logic [TBS_W-1:0]  tbs_val,
    output logic [SIZE_W-1:0] size_bits,
    output logic [SIZE_W-1:0] pad_bits,
    output logic [PAY_W-1:0]  payload,
    output logic              done
);
    logic [WID_W-1:0] fw;
    logic             go;
    ra_fields_t       fields;

    assign go     = start && (rnti_kind == RNTI_RACH);
    assign fields = '{freq: freq_val, tdra: tdra_val, mcs: mcs_val, tbs: tbs_val};

    dci_freq_width #(.NRB_W_P(NRB_W), .NRB_MAX_P(NRB_MAX), .WID_W_P(WID_W)) u_width (
        .n_rb (n_rb),
        .fw   (fw)
    );

    dci_size_calc #(.WID_W_P(WID_W), .SIZE_W_P(SIZE_W),
                    .DL_FIXED_P(DL_FIXED), .UL_FIXED_P(UL_FIXED)) u_size (
        .clk    (clk),
        .rst    (rst),
        .fw     (fw),
        .fmt_ul (fmt_ul),
        .size_q (size_bits),
        .pad_q  (pad_bits)
    );

    dci_ra_packer u_pack (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .fw      (fw),
        .fields  (fields),
        .payload (payload),
        .done    (done)
    );

    a_r1_width_bound: assert property (@(posedge clk) disable iff (rst)
        fw <= WID_W'(VAL_W));
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done && payload == '0));
endmodule

// File: tb/tb_dci_payload_unit.sv
module tb_dci_payload_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  n_rb;
    logic        fmt_ul;
    logic [1:0]  rnti_kind;
    logic        start;
    logic [15:0] freq_val;
    logic [3:0]  tdra_val;
    logic [4:0]  mcs_val;
    logic [1:0]  tbs_val;
    logic [6:0]  size_bits;
    logic [6:0]  pad_bits;
    logic [63:0] payload;
    logic        done;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dci_payload_unit dut (
        .clk(clk), .rst(rst), .n_rb(n_rb), .fmt_ul(fmt_ul), .rnti_kind(rnti_kind),
        .start(start), .freq_val(freq_val), .tdra_val(tdra_val), .mcs_val(mcs_val),
        .tbs_val(tbs_val), .size_bits(size_bits), .pad_bits(pad_bits),
        .payload(payload), .done(done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic int tri_width(input int n);
        int nn, t, w;
        nn = (n < 1) ? 1 : ((n > 275) ? 275 : n);
        t  = nn * (nn + 1) / 2;
        w  = 0;
        while ((1 << w) < t) w++;
        return w;
    endfunction

    function automatic logic [63:0] put(input int v, input int len, input int pos);
        logic [63:0] r;
        r = '0;
        for (int j = 0; j < len; j++) r[pos + j] = 1'((v >> (len - 1 - j)) & 1);
        return r;
    endfunction

    int          m_size, m_pad, m_cnt, cw, cf, ct, cm, cb;
    logic [63:0] m_pay;
    logic        m_done;
    bit          seen = 0;

    always @(posedge clk) begin
        seen = 1;
        if (rst) begin
            m_size = 0; m_pad = 0; m_pay = '0; m_done = 0; m_cnt = 0;
        end else begin
            m_size = 28 + tri_width(int'(n_rb));
            m_pad  = fmt_ul ? 8 : 0;
            m_done = 0;
            case (m_cnt)
                0: if (start && rnti_kind == 2'd1) begin
                    m_pay = '0; cw = tri_width(int'(n_rb));
                    cf = int'(freq_val); ct = int'(tdra_val); cm = int'(mcs_val); cb = int'(tbs_val);
                    m_cnt = 1;
                end
                1: begin m_pay = m_pay | put(cf & ((1 << cw) - 1), cw, 0); m_cnt = 2; end
                2: begin m_pay = m_pay | put(ct, 4, cw);     m_cnt = 3; end
                3: begin m_pay = m_pay | put(cm, 5, cw + 4); m_cnt = 4; end
                default: begin m_pay = m_pay | put(cb, 2, cw + 9); m_done = 1; m_cnt = 0; end
            endcase
        end
    end

    always @(negedge clk) begin
        if (seen) begin
            chk("R2 size_bits per cycle", 64'(size_bits), 64'(m_size));
            chk("R3 pad_bits per cycle",  64'(pad_bits),  64'(m_pad));
            chk("R6 payload per cycle",   payload,        m_pay);
            chk("R5 done per cycle",      64'(done),      64'(m_done));
        end
    end

    // ---------------- stimulus ----------------
    task automatic start_pack(input logic [1:0] rk, input logic [15:0] f,
                              input logic [3:0] t, input logic [4:0] m, input logic [1:0] b);
        rnti_kind = rk; freq_val = f; tdra_val = t; mcs_val = m; tbs_val = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_nrb(input logic [8:0] n);
        n_rb = n;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; n_rb = 9'd24; fmt_ul = 1'b0; rnti_kind = 2'd0; start = 1'b0;
        freq_val = '0; tdra_val = '0; mcs_val = '0; tbs_val = '0;
        repeat (3) @(negedge clk);
        chk("R10 size in reset", 64'(size_bits), 64'd0);
        chk("R10 pad in reset", 64'(pad_bits), 64'd0);
        chk("R10 payload in reset", payload, 64'd0);
        chk("R10 done in reset", 64'(done), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 size for N=24", 64'(size_bits), 64'd37);
        fmt_ul = 1'b1;
        @(negedge clk);
        chk("R3 uplink size matches", 64'(size_bits), 64'd37);
        chk("R3 uplink padding", 64'(pad_bits), 64'd8);
        fmt_ul = 1'b0;
        set_nrb(9'd1);   chk("R1 size for N=1", 64'(size_bits), 64'd28);
        set_nrb(9'd2);   chk("R1 size for N=2", 64'(size_bits), 64'd30);
        set_nrb(9'd275); chk("R1 size for N=275", 64'(size_bits), 64'd44);
        set_nrb(9'd0);   chk("R4 zero clamps to one", 64'(size_bits), 64'd28);
        set_nrb(9'd400); chk("R4 large clamps to max", 64'(size_bits), 64'd44);
        set_nrb(9'd511); chk("R4 all-ones clamps to max", 64'(size_bits), 64'd44);
        set_nrb(9'd24);

        // R5 and R6: basic random-access packing
        start_pack(2'd1, 16'd5, 4'd2, 5'd3, 2'd1);
        repeat (3) @(negedge clk);
        chk("R5 done not early", 64'(done), 64'd0);
        @(negedge clk);
        chk("R5 done on fourth edge", 64'(done), 64'd1);
        chk("R6 field layout", payload, 64'h00000000000B0940);
        @(negedge clk);
        chk("R5 done lasts one cycle", 64'(done), 64'd0);

        // R7: non random-access starts are ignored
        for (int k = 0; k < 4; k++) begin
            if (k != 1) begin
                start_pack(2'(k), 16'hFFFF, 4'hF, 5'h1F, 2'h3);
                repeat (5) begin
                    @(negedge clk);
                    chk("R7 no done", 64'(done), 64'd0);
                    chk("R7 payload held", payload, 64'h00000000000B0940);
                end
            end
        end

        // R8: second start mid-pack is ignored
        start_pack(2'd1, 16'd0, 4'hF, 5'd0, 2'd0);
        @(negedge clk);
        start_pack(2'd1, 16'h01FF, 4'd5, 5'd7, 2'd2);
        repeat (2) @(negedge clk);
        chk("R8 first done on time", 64'(done), 64'd1);
        chk("R8 first result kept", payload, 64'h0000000000001E00);
        repeat (5) begin
            @(negedge clk);
            chk("R8 no second done", 64'(done), 64'd0);
        end

        // R9: width captured at start, size tracks the new value
        start_pack(2'd1, 16'd5, 4'd2, 5'd3, 2'd1);
        n_rb = 9'd2;
        repeat (4) @(negedge clk);
        chk("R9 done", 64'(done), 64'd1);
        chk("R9 payload uses captured width", payload, 64'h00000000000B0940);
        chk("R9 size follows new n_rb", 64'(size_bits), 64'd30);

        // R11: excess frequency bits dropped, upper bits clear
        start_pack(2'd1, 16'hFFFF, 4'd0, 5'd0, 2'd0);
        repeat (4) @(negedge clk);
        chk("R11 narrow field truncated", payload, 64'h0000000000000003);
        n_rb = 9'd275;
        start_pack(2'd1, 16'hFFFF, 4'hF, 5'h1F, 2'h3);
        repeat (4) @(negedge clk);
        chk("R11 widest payload", payload, 64'h0000000007FFFFFF);
        chk("R11 done", 64'(done), 64'd1);
        repeat (3) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule